// File: doc/BRIEF.md
# SPI Status Flag Controller

This block keeps the status and control flags of a serial peripheral interface and decides when each one is raised and when it is lowered. A CPU reaches it through strobes for the status register (read and write) and for the data register (read and write). The shift engine beside it reports a finished transfer and whether a transfer is under way. The select pin's level comes in from the pad.

Three flags are held: a transfer interrupt flag, a write-collision flag and a select-high flag. Two control bits are also held: one swaps the roles of the two data pins, and one turns on select-pin operation. The interrupt and collision flags are cleared by a two-step handshake, a status read followed by any data-register access. While the interrupt is enabled, the interrupt flag is cleared by the acknowledge pulse instead. The select-high flag is cleared by writing zero to its bit. In every case, a set event that meets a clear condition in the same cycle leaves the flag set.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset the status read value `stat_rdata` is 0x00 and `irq` is 0.
- R2: A cycle with `xfer_done` high sets the interrupt flag (bit 7 of `stat_rdata`) from the next cycle on.
- R3: While `int_en` is 1, an `int_ack` pulse clears the interrupt flag, and the read-then-access handshake leaves it unchanged.
- R4: While `int_en` is 0, the interrupt flag is cleared only by a `data_rd` or `data_wr` that follows a `stat_rd`. A data access with no preceding status read leaves it set, and so does `int_ack`.
- R5: Status writes never change bit 7 (interrupt flag) or bit 6 (collision flag), whatever value is written.
- R6: A `data_wr` while `xfer_busy` is high sets the collision flag (bit 6). A `data_wr` while idle does not. The read-then-access handshake clears it.
- R7: While the select-enable bit is 1 and `ss_pin` is high, the select-high flag (bit 5) is set. With select disabled it is not set. Writing 0 to bit 5 clears it, and writing 1 leaves it unchanged.
- R8: A status write loads bit 4 into `pin_swap` and bit 3 into `ss_enable`, and both read back in the same positions.
- R9: A status read arms exactly one data access. The first access after the read clears the flags, and a second access with no new read clears nothing.
- R10: When a set event and a clear condition for the same flag fall in one cycle, the flag ends up set.
- R11: `irq` equals the interrupt flag ANDed with `int_en`.
- R12: Bits 2 to 0 of `stat_rdata` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| wdata | input | 8 | Write data for the status register |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| int_en | input | 1 | Interrupt enable |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| xfer_done | input | 1 | Transfer complete event |
| xfer_busy | input | 1 | Transfer in progress |
| ss_pin | input | 1 | Select pin level |
| stat_rdata | output | 8 | Status register read value |
| irq | output | 1 | Interrupt request |
| wcol | output | 1 | Write-collision flag |
| ss_high | output | 1 | Select-high flag |
| pin_swap | output | 1 | Swap data pin roles when 1 |
| ss_enable | output | 1 | Select pin operation enabled |

## Verification
The bench builds the block with its fixed 8-bit status layout, which has no parameter that changes behaviour. The state is small: five stored bits plus the armed step. A sweep of 4096 consecutive cycles, with the nine strobes and levels and the written control bits taken from a scrambled counter, passes through almost every combination of prior state and input. In that sweep, simultaneous set and clear, acknowledge with and without enable, and handshakes broken by a second access all occur many times. Each cycle is compared against a model that the bench writes as priority conditionals.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_INT   = 7;
  localparam int BIT_WCOL  = 6;
  localparam int BIT_SSHI  = 5;
  localparam int BIT_SWAP  = 4;
  localparam int BIT_SSEN  = 3;
  localparam int LOW_ZEROS = BIT_SSEN;

  // set has priority, so an event that meets a clear is kept
  function automatic logic flag_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic logic [REG_W-1:0] pack_status(
    input logic f_int, input logic f_wcol, input logic f_sshi,
    input logic c_swap, input logic c_ssen);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_INT]  = f_int;
    v[BIT_WCOL] = f_wcol;
    v[BIT_SSHI] = f_sshi;
    v[BIT_SWAP] = c_swap;
    v[BIT_SSEN] = c_ssen;
    return v;
  endfunction
endpackage

// File: rtl/spi_clear_seq.sv
module spi_clear_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic data_acc,
  output logic armed,
  output logic seq_clr
);
  assign seq_clr = armed & data_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b0;
    else if (stat_rd)  armed <= 1'b1;
    else if (data_acc) armed <= 1'b0;
  end
endmodule

// File: rtl/spi_evt_flag.sv
module spi_evt_flag
  import spi_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= flag_next(q, set, clr);
  end
endmodule

// File: rtl/spi_ctrl_bits.sv
module spi_ctrl_bits
  import spi_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic             swap,
  output logic             ssen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap <= 1'b0;
      ssen <= 1'b0;
    end else if (wr) begin
      swap <= wdata[BIT_SWAP];
      ssen <= wdata[BIT_SSEN];
    end
  end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_rd,
  input  logic             stat_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             data_rd,
  input  logic             data_wr,
  input  logic             int_en,
  input  logic             int_ack,
  input  logic             xfer_done,
  input  logic             xfer_busy,
  input  logic             ss_pin,
  output logic [REG_W-1:0] stat_rdata,
  output logic             irq,
  output logic             wcol,
  output logic             ss_high,
  output logic             pin_swap,
  output logic             ss_enable
);
  // named internal events, visible to the bound checker
  logic data_acc, armed, seq_clr;
  logic int_flag, int_set, int_clr;
  logic wcol_set, sshi_set, sshi_clr;
  logic [REG_W-1:0] unused_wdata;

  assign unused_wdata = wdata;
  assign data_acc = data_rd | data_wr;

  spi_clear_seq u_seq (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_acc(data_acc),
    .armed(armed), .seq_clr(seq_clr)
  );

  assign int_set  = xfer_done;
  assign int_clr  = int_en ? int_ack : seq_clr;
  assign wcol_set = data_wr & xfer_busy;
  assign sshi_set = ss_enable & ss_pin;
  assign sshi_clr = stat_wr & ~wdata[BIT_SSHI];

  spi_evt_flag u_int (
    .clk(clk), .rst_n(rst_n), .set(int_set), .clr(int_clr), .q(int_flag)
  );
  spi_evt_flag u_wcol (
    .clk(clk), .rst_n(rst_n), .set(wcol_set), .clr(seq_clr), .q(wcol)
  );
  spi_evt_flag u_sshi (
    .clk(clk), .rst_n(rst_n), .set(sshi_set), .clr(sshi_clr), .q(ss_high)
  );

  spi_ctrl_bits u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(stat_wr), .wdata(wdata),
    .swap(pin_swap), .ssen(ss_enable)
  );

  assign stat_rdata = pack_status(int_flag, wcol, ss_high, pin_swap, ss_enable);
  assign irq        = int_flag & int_en;
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_rd,
  input logic       stat_wr,
  input logic       data_wr,
  input logic       int_en,
  input logic       int_ack,
  input logic       xfer_done,
  input logic       xfer_busy,
  input logic       ss_pin,
  input logic [7:0] stat_rdata,
  input logic       irq,
  input logic       wcol,
  input logic       ss_high,
  input logic       ss_enable,
  input logic       armed,
  input logic       seq_clr
);
  assert_done_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> stat_rdata[7]);

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && int_ack && !xfer_done) |=> !stat_rdata[7]);

  assert_no_unarmed_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en && stat_rdata[7] && !armed) |=> stat_rdata[7]);

  assert_status_write_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !xfer_done && !seq_clr && !int_ack) |=> $stable(stat_rdata[7]));

  assert_collision_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && xfer_busy) |=> wcol);

  assert_sshigh_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_enable && ss_pin) |=> ss_high);

  assert_arm_consumed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_clr && !stat_rd) |=> !armed);

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_en && stat_rdata[7]));

  assert_low_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[2:0] == 3'b000);
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .stat_wr(stat_wr),
  .data_wr(data_wr), .int_en(int_en), .int_ack(int_ack),
  .xfer_done(xfer_done), .xfer_busy(xfer_busy), .ss_pin(ss_pin),
  .stat_rdata(stat_rdata), .irq(irq), .wcol(wcol), .ss_high(ss_high),
  .ss_enable(ss_enable), .armed(armed), .seq_clr(seq_clr)
);

// File: tb/spi_flag_ctrl_test.sv
`timescale 1ns/1ps
module spi_flag_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_rd, stat_wr, data_rd, data_wr, int_en, int_ack;
  logic xfer_done, xfer_busy, ss_pin;
  logic [7:0] wdata;
  logic [7:0] stat_rdata;
  logic irq, wcol, ss_high, pin_swap, ss_enable;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench model state
  logic m_arm, m_if, m_wc, m_sh, m_sw, m_se;

  always #2.5 clk = ~clk;

  spi_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .stat_wr(stat_wr),
    .wdata(wdata), .data_rd(data_rd), .data_wr(data_wr), .int_en(int_en),
    .int_ack(int_ack), .xfer_done(xfer_done), .xfer_busy(xfer_busy),
    .ss_pin(ss_pin), .stat_rdata(stat_rdata), .irq(irq), .wcol(wcol),
    .ss_high(ss_high), .pin_swap(pin_swap), .ss_enable(ss_enable)
  );

  task automatic idle();
    stat_rd = 0; stat_wr = 0; data_rd = 0; data_wr = 0; int_ack = 0;
    xfer_done = 0; xfer_busy = 0; ss_pin = 0; wdata = 8'h00;
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_val();
    return {m_if, m_wc, m_sh, m_sw, m_se, 3'b000};
  endfunction

  // one clock: advance the model, let the edge pass, compare at negedge
  task automatic tick();
    logic acc, hs, ien;
    logic n_if, n_wc, n_sh;
    acc = data_rd | data_wr;
    hs  = m_arm && acc;
    ien = int_en;
    if (xfer_done) n_if = 1;
    else if (ien ? int_ack : hs) n_if = 0;
    else n_if = m_if;
    if (data_wr && xfer_busy) n_wc = 1;
    else if (hs) n_wc = 0;
    else n_wc = m_wc;
    if (m_se && ss_pin) n_sh = 1;
    else if (stat_wr && !wdata[5]) n_sh = 0;
    else n_sh = m_sh;
    if (stat_wr) begin m_sw = wdata[4]; m_se = wdata[3]; end
    m_arm = stat_rd ? 1'b1 : (acc ? 1'b0 : m_arm);
    m_if = n_if; m_wc = n_wc; m_sh = n_sh;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (stat_rdata !== model_val() || irq !== (m_if & ien) ||
        wcol !== m_wc || ss_high !== m_sh || pin_swap !== m_sw || ss_enable !== m_se) begin
      fails++;
      if (stat_rdata[7] !== m_if)
        $display("FAIL R3/R4 int flag: actual %h expected %h", stat_rdata, model_val());
      else if (stat_rdata[6] !== m_wc || wcol !== m_wc)
        $display("FAIL R6 collision: actual %h expected %h", stat_rdata, model_val());
      else if (stat_rdata[5] !== m_sh || ss_high !== m_sh)
        $display("FAIL R7 select-high: actual %h expected %h", stat_rdata, model_val());
      else if (irq !== (m_if & ien))
        $display("FAIL R11 irq: actual %b expected %b", irq, m_if & ien);
      else
        $display("FAIL R8 control bits: actual %h/%b%b expected %h", stat_rdata,
                 pin_swap, ss_enable, model_val());
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle();
    int_en = 0;
    m_arm = 0; m_if = 0; m_wc = 0; m_sh = 0; m_sw = 0; m_se = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset status", stat_rdata, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);

    // R2 set by transfer complete
    xfer_done = 1; tick(); idle();
    check("R2 flag set", stat_rdata, 8'h80);
    // R5 writes do not touch bits 7/6
    stat_wr = 1; wdata = 8'h40; tick(); idle();
    check("R5 write 0 to bit7", {stat_rdata[7:6], 6'b0}, 8'h80);
    // R4 access without read does nothing; ack ignored when disabled
    data_rd = 1; tick(); idle();
    int_ack = 1; tick(); idle();
    check("R4 unarmed/ack", {stat_rdata[7], 7'b0}, 8'h80);
    stat_rd = 1; tick(); idle();
    data_wr = 1; tick(); idle();
    check("R4 handshake clear", {stat_rdata[7], 7'b0}, 8'h00);
    // R11 / R3 with interrupt enabled
    int_en = 1;
    xfer_done = 1; tick(); idle();
    check("R11 irq high", {7'b0, irq}, 8'h01);
    stat_rd = 1; tick(); idle();
    data_rd = 1; tick(); idle();
    check("R3 handshake ignored", {stat_rdata[7], 7'b0}, 8'h80);
    int_ack = 1; tick(); idle();
    check("R3 ack clears", {stat_rdata[7], irq, 6'b0}, 8'h00);
    int_en = 0;
    // R6 collision
    data_wr = 1; tick(); idle();
    check("R6 idle write", {7'b0, wcol}, 8'h00);
    data_wr = 1; xfer_busy = 1; tick(); idle();
    check("R6 busy write", {stat_rdata[6], 7'b0}, 8'h80);
    stat_rd = 1; tick(); idle();
    data_rd = 1; tick(); idle();
    check("R6 handshake clear", {7'b0, wcol}, 8'h00);
    // R9 one access per read
    xfer_done = 1; tick(); idle();
    stat_rd = 1; tick(); idle();
    data_rd = 1; tick(); idle();
    xfer_done = 1; tick(); idle();
    data_rd = 1; tick(); idle();
    check("R9 second access", {stat_rdata[7], 7'b0}, 8'h80);
    // R10 set beats clear
    stat_rd = 1; tick(); idle();
    data_rd = 1; xfer_done = 1; tick(); idle();
    check("R10 set wins", {stat_rdata[7], 7'b0}, 8'h80);
    // R7 select-high
    ss_pin = 1; tick(); idle();
    check("R7 disabled", {7'b0, ss_high}, 8'h00);
    stat_wr = 1; wdata = 8'h08; tick(); idle();
    check("R8 ss enable", {7'b0, ss_enable}, 8'h01);
    ss_pin = 1; tick(); idle();
    check("R7 set", {stat_rdata[5], 7'b0}, 8'h80);
    stat_wr = 1; wdata = 8'h28; tick(); idle();
    check("R7 write 1 keeps", {7'b0, ss_high}, 8'h01);
    stat_wr = 1; wdata = 8'h08; tick(); idle();
    check("R7 write 0 clears", {7'b0, ss_high}, 8'h00);
    // R8 swap, R12 low bits
    stat_wr = 1; wdata = 8'h10; tick(); idle();
    check("R8 swap", {6'b0, pin_swap, ss_enable}, 8'h02);
    stat_wr = 1; wdata = 8'hFF; tick(); idle();
    check("R12 low bits", {5'b0, stat_rdata[2:0]}, 8'h00);

    // sweep over scrambled input combinations
    for (int k = 0; k < 4096; k++) begin
      logic [15:0] p;
      p = 16'(k) ^ 16'((k >> 3) * 5) ^ 16'((k >> 7) * 11);
      stat_rd = p[0]; data_rd = p[1]; data_wr = p[2]; stat_wr = p[3];
      int_en = p[4]; int_ack = p[5]; xfer_done = p[6] & p[9];
      xfer_busy = p[7]; ss_pin = p[8] & p[10];
      wdata = {p[11], p[12], p[13], p[14], p[15] ^ p[1], 3'b101};
      tick();
    end
    idle();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule